// File: doc/BRIEF.md
# Match-Action Watchdog Timer

This block is a memory-mapped watchdog. A free-running 32-bit up-counter advances once per counter-clock cycle while enabled. Each cycle it is compared with a programmable match value. When the two are equal, a set of enabled actions fires once. The block can latch an interrupt flag, clear and stop the counter, change an external match pin, and start a reset pulse on an internal reset line, an external reset line, or both. The pulse length is programmable.

Software loads the match value as the timeout in counter ticks and selects the match actions. It then starts the counter. To keep the system alive, software clears and restarts the counter before the match value is reached. A sticky reset-cause flag records that the watchdog issued a reset. Only a power-on reset clears this flag, so boot code can tell why the system restarted. Every register sits behind a single-cycle port: a write is captured on the clock edge, and a read is returned combinationally.

Top module: `match_watchdog`

## Requirements
- R1: The registers sit at byte addresses 0x00 (interrupt flag, bit 0), 0x04 (control, bits 2:0), 0x08 (counter), 0x0C (match actions, bits 6:2 and 0), 0x10 (match value), 0x14 (pin control, bits 5:4 and 0), 0x18 (pulse length, bits 15:0) and 0x1C (reset cause, bit 0). Bits that are not implemented read as zero.
- R2: While control bit 0 is set, the counter rises by exactly one per clock. While bit 0 is clear, the counter keeps its value.
- R3: While control bit 1 is set, the counter is cleared to zero and held there, whatever bit 0 holds.
- R4: When control bit 2 is set and the debug-halt input is high, the counter holds. If bit 2 is clear, the debug-halt input has no effect.
- R5: A match (counter equal to the match value while counting) sets interrupt flag bit 0. Writing 1 to that bit clears it. irqOut is the flag ANDed with match-action bit 0. Each match sets the flag only once.
- R6: When match-action bit 2 is set, a match clears the counter to zero and clears control bit 0, which stops the counter.
- R7: On a match, pin-control bits 5:4 act on pin-control bit 0 as follows: 0 leaves it unchanged, 1 drives it low, 2 drives it high, 3 toggles it. matchPin always equals pin-control bit 0.
- R8: A match starts a reset pulse that lasts the pulse-length value plus 6 clock cycles. The pulse appears on rstIntOut if match-action bit 3 is set, and on rstExtOut if bit 4 is set.
- R9: Match-action bit 5 forces rstIntOut high and bit 6 forces rstExtOut high, independent of any match.
- R10: Reset-cause bit 0 is set when a watchdog reset pulse starts. It is read-only and is cleared only by rstPorN.
- R11: Writes to the counter register and to the reset-cause register have no effect.
- R12: After rstPorN, every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, which also clocks the register port |
| rstPorN | input | 1 | Asynchronous active-low power-on reset |
| dbgHalt | input | 1 | Debug-halt request; holds the counter when control bit 2 is set |
| busAddr | input | 5 | Byte address of the register |
| busWe | input | 1 | Write strobe, captured on the clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, returned combinationally |
| irqOut | output | 1 | Match interrupt |
| matchPin | output | 1 | External match output |
| rstIntOut | output | 1 | Internal reset request |
| rstExtOut | output | 1 | External reset request |

## Verification
The bench measures the reset pulse width cycle by cycle. It does this at a small length and again at the largest length, 65541 cycles, so an off-by-one in the pulse counter, or a counter that is too narrow, shows up as a wrong count. After a match it clears the interrupt flag and keeps the counter running, then checks that the flag stays clear. A design that re-fires while the counter passes or sits on the match value would set the flag again. It also checks the following cases, each of which a faulty design would get wrong:
- All four pin actions. A swapped or mis-decoded action code would leave the pin in the wrong state.
- Debug hold, both with and without control bit 2 set. A design that ignores bit 2 would stop the counter whenever the debug-halt input is high.
- The stop action. A design without it would keep counting past the timeout.
- The reset-cause flag. The bench tries to clear it by writing to it and by restarting the counter, and expects it to stay set until a power-on reset. A flag that is not truly sticky would be lost.

// File: rtl/mwd_pkg.sv
`timescale 1ns/1ps
package mwd_pkg;
  localparam int BUS_W       = 32;
  localparam int ADDR_W      = 5;
  localparam int PULSE_W     = 16;
  localparam int PULSE_EXTRA = 6;
  localparam int PCNT_W      = PULSE_W + 1;

  typedef enum logic [2:0] {
    IDX_IRQ   = 3'd0,
    IDX_CTRL  = 3'd1,
    IDX_COUNT = 3'd2,
    IDX_ACT   = 3'd3,
    IDX_MVAL  = 3'd4,
    IDX_PIN   = 3'd5,
    IDX_PULSE = 3'd6,
    IDX_CAUSE = 3'd7
  } regIdx_e;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_TOGGLE = 2'd3
  } pinAct_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              cntEn;
    logic              cntClr;
    logic              pulseStart;
    logic [PCNT_W-1:0] pulseLoad;
  } dpStrb_t;
endpackage

// File: rtl/mwd_datapath.sv
`timescale 1ns/1ps
module mwd_datapath
  import mwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrb_t          strb,
  input  logic [CNT_W-1:0] matchVal,
  output logic [CNT_W-1:0] count,
  output logic             matchHit,
  output logic             pulseActive
);
  logic [PCNT_W-1:0] pulseLeft;

  // main up-counter; clear has priority over increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strb.cntClr) count <= '0;
    else if (strb.cntEn)  count <= count + CNT_W'(1);
  end

  assign matchHit = strb.cntEn && (count == matchVal);

  // reset pulse timer: active for pulseLoad+1 cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseLeft   <= '0;
      pulseActive <= 1'b0;
    end else if (strb.pulseStart) begin
      pulseLeft   <= strb.pulseLoad;
      pulseActive <= 1'b1;
    end else if (pulseActive) begin
      if (pulseLeft == '0) pulseActive <= 1'b0;
      else                 pulseLeft   <= pulseLeft - PCNT_W'(1);
    end
  end
endmodule

// File: rtl/mwd_ctrl.sv
`timescale 1ns/1ps
module mwd_ctrl
  import mwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dbgHalt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              matchHit,
  input  logic              pulseActive,
  output dpStrb_t           strb,
  output logic [CNT_W-1:0]  matchVal,
  output logic              irqOut,
  output logic              matchPin,
  output logic [1:0]        rstOut
);
  localparam int NUM_RST = 2;

  regIdx_e            regIdx;
  logic               wrIrq, wrCtrl, wrAct, wrMval, wrPin, wrPulse;
  logic               intFlag;
  logic [2:0]         ctrlReg;
  logic               irqEn, stopOnMatch;
  logic [NUM_RST-1:0] rstEn, rstForce, rstSel;
  logic               pinState;
  pinAct_e            pinAct;
  logic [PULSE_W-1:0] pulseLen;
  logic               rstFlag;
  logic               unusedBits;

  assign regIdx  = regIdx_e'(busAddr[4:2]);
  assign wrIrq   = busWe && (regIdx == IDX_IRQ);
  assign wrCtrl  = busWe && (regIdx == IDX_CTRL);
  assign wrAct   = busWe && (regIdx == IDX_ACT);
  assign wrMval  = busWe && (regIdx == IDX_MVAL);
  assign wrPin   = busWe && (regIdx == IDX_PIN);
  assign wrPulse = busWe && (regIdx == IDX_PULSE);
  assign unusedBits = ^{busAddr[1:0], busWdata[BUS_W-1:PULSE_W]};

  // strobes to datapath
  always_comb begin
    strb            = '0;
    strb.cntEn      = ctrlReg[0] && !ctrlReg[1] && !(ctrlReg[2] && dbgHalt);
    strb.cntClr     = ctrlReg[1] || (matchHit && stopOnMatch);
    strb.pulseStart = matchHit && (|rstEn);
    strb.pulseLoad  = PCNT_W'(pulseLen) + PCNT_W'(PULSE_EXTRA - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrCtrl) begin
      ctrlReg <= busWdata[2:0];
    end else if (matchHit && stopOnMatch) begin
      ctrlReg[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         intFlag <= 1'b0;
    else if (matchHit)                 intFlag <= 1'b1;
    else if (wrIrq && busWdata[0])     intFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn       <= 1'b0;
      stopOnMatch <= 1'b0;
      rstEn       <= '0;
      rstForce    <= '0;
      matchVal    <= '0;
      pulseLen    <= '0;
      pinAct      <= PIN_KEEP;
    end else begin
      if (wrAct) begin
        irqEn       <= busWdata[0];
        stopOnMatch <= busWdata[2];
        rstEn       <= busWdata[4:3];
        rstForce    <= busWdata[6:5];
      end
      if (wrMval)  matchVal <= busWdata[CNT_W-1:0];
      if (wrPulse) pulseLen <= busWdata[PULSE_W-1:0];
      if (wrPin)   pinAct   <= pinAct_e'(busWdata[5:4]);
    end
  end

  // match pin: match action wins over a same-cycle write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinState <= 1'b0;
    end else if (matchHit && pinAct != PIN_KEEP) begin
      unique case (pinAct)
        PIN_LOW:    pinState <= 1'b0;
        PIN_HIGH:   pinState <= 1'b1;
        PIN_TOGGLE: pinState <= !pinState;
        default:    pinState <= pinState;
      endcase
    end else if (wrPin) begin
      pinState <= busWdata[0];
    end
  end

  // reset-channel selection and sticky cause flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstSel  <= '0;
      rstFlag <= 1'b0;
    end else if (strb.pulseStart) begin
      rstSel  <= rstEn;
      rstFlag <= 1'b1;
    end
  end

  for (genvar ch = 0; ch < NUM_RST; ch++) begin : g_rst
    assign rstOut[ch] = (pulseActive && rstSel[ch]) || rstForce[ch];
  end

  assign irqOut   = intFlag && irqEn;
  assign matchPin = pinState;

  always_comb begin
    busRdata = '0;
    unique case (regIdx)
      IDX_IRQ:   busRdata[0]   = intFlag;
      IDX_CTRL:  busRdata[2:0] = ctrlReg;
      IDX_COUNT: busRdata      = BUS_W'(count);
      IDX_ACT:   busRdata[6:0] = {rstForce, rstEn, stopOnMatch, 1'b0, irqEn};
      IDX_MVAL:  busRdata      = BUS_W'(matchVal);
      IDX_PIN:   busRdata[5:0] = {pinAct, 3'b000, pinState};
      IDX_PULSE: busRdata[PULSE_W-1:0] = pulseLen;
      IDX_CAUSE: busRdata[0]   = rstFlag;
      default:   busRdata      = '0;
    endcase
  end
endmodule

// File: rtl/match_watchdog.sv
`timescale 1ns/1ps
module match_watchdog
  import mwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstPorN,
  input  logic              dbgHalt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irqOut,
  output logic              matchPin,
  output logic              rstIntOut,
  output logic              rstExtOut
);
  dpStrb_t          strb;
  logic [CNT_W-1:0] count, matchVal;
  logic             matchHit, pulseActive;
  logic [1:0]       rstOut;

  mwd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstPorN), .dbgHalt(dbgHalt),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .count(count), .matchHit(matchHit), .pulseActive(pulseActive),
    .strb(strb), .matchVal(matchVal),
    .irqOut(irqOut), .matchPin(matchPin), .rstOut(rstOut)
  );

  mwd_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstPorN), .strb(strb), .matchVal(matchVal),
    .count(count), .matchHit(matchHit), .pulseActive(pulseActive)
  );

  assign rstIntOut = rstOut[0];
  assign rstExtOut = rstOut[1];
endmodule

// File: rtl/mwd_chk.sv
`timescale 1ns/1ps
module mwd_chk
  import mwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             dbgHalt,
  input logic             busWe,
  input logic [2:0]       ctrlReg,
  input logic             stopOnMatch,
  input logic             matchHit,
  input logic [CNT_W-1:0] count,
  input logic             intFlag,
  input logic             rstFlag,
  input logic             pulseActive,
  input dpStrb_t          strb
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntEn && !strb.cntClr |=> count == $past(count) + CNT_W'(1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[0] && !ctrlReg[1] |=> $stable(count));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[1] |=> count == '0);

  p_dbg_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[2] && dbgHalt && !ctrlReg[1] |=> $stable(count));

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> intFlag);

  p_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    matchHit && stopOnMatch && !busWe |=> count == '0 && !ctrlReg[0]);

  p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.pulseStart |=> pulseActive && rstFlag);

  p_cause_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    rstFlag |=> rstFlag);
endmodule

bind mwd_ctrl mwd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .dbgHalt(dbgHalt), .busWe(busWe),
  .ctrlReg(ctrlReg), .stopOnMatch(stopOnMatch), .matchHit(matchHit),
  .count(count), .intFlag(intFlag), .rstFlag(rstFlag),
  .pulseActive(pulseActive), .strb(strb)
);

// File: tb/match_watchdog_tb.sv
`timescale 1ns/1ps
module match_watchdog_tb;
  logic        clk = 1'b0;
  logic        rstPorN = 1'b0;
  logic        dbgHalt = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, matchPin, rstIntOut, rstExtOut;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  localparam logic [7:0] A_IRQ = 8'h00, A_CTRL = 8'h04, A_CNT = 8'h08, A_ACT = 8'h0C,
                         A_MVAL = 8'h10, A_PIN = 8'h14, A_PULSE = 8'h18, A_CAUSE = 8'h1C;

  // {address, write data, expected read-back}; R1 masks, R11 ignored writes
  localparam int NVEC = 11;
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h10, 32'h12345678, 32'h12345678},
    {8'h18, 32'h000ABCDE, 32'h0000BCDE},
    {8'h0C, 32'hFFFFFFFF, 32'h0000007D},
    {8'h0C, 32'h00000000, 32'h00000000},
    {8'h14, 32'hFFFFFFFF, 32'h00000031},
    {8'h14, 32'h00000000, 32'h00000000},
    {8'h1C, 32'h00000001, 32'h00000000},
    {8'h08, 32'hDEADBEEF, 32'h00000000},
    {8'h04, 32'hFFFFFFF8, 32'h00000000},
    {8'h00, 32'h00000001, 32'h00000000},
    {8'h10, 32'h00000000, 32'h00000000}
  };

  match_watchdog u_dut (
    .clk(clk), .rstPorN(rstPorN), .dbgHalt(dbgHalt), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .matchPin(matchPin), .rstIntOut(rstIntOut), .rstExtOut(rstExtOut)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a[4:0]; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    #1 busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a[4:0]; busWe = 1'b0;
    #1 d = busRdata;
  endtask

  task automatic restart();
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h1);
  endtask

  task automatic por();
    @(negedge clk); rstPorN = 1'b0;
    repeat (2) @(negedge clk);
    rstPorN = 1'b1;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    int hiInt, hiExt;
    por();

    // R12: reset state
    for (int i = 0; i < 8; i++) begin
      rd(8'(i * 4), a);
      check("R12 register zero", a, 32'h0);
    end
    check("R12 outputs low", {28'h0, irqOut, matchPin, rstIntOut, rstExtOut}, 32'h0);

    // R1/R11 table
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], a);
      check($sformatf("R1 R11 table entry %0d", i), a, VEC[i][31:0]);
    end

    // R2: counting and holding
    restart();
    rd(A_CNT, a); repeat (7) @(posedge clk); rd(A_CNT, b);
    check("R2 counts one per cycle", b - a, 32'd7);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, a); repeat (10) @(posedge clk); rd(A_CNT, b);
    check("R2 holds when disabled", b, a);
    check("R2 held value nonzero", 32'(a != 0), 32'd1);

    // R3: clear request
    wr(A_CTRL, 32'h3);
    repeat (2) @(posedge clk);
    rd(A_CNT, a);
    check("R3 counter cleared", a, 32'h0);
    repeat (5) @(posedge clk);
    rd(A_CNT, a);
    check("R3 counter held at zero", a, 32'h0);

    // R4: debug hold
    dbgHalt = 1'b1;
    wr(A_CTRL, 32'h2); wr(A_CTRL, 32'h5);
    rd(A_CNT, a); repeat (6) @(posedge clk); rd(A_CNT, b);
    check("R4 held in debug", b, a);
    wr(A_CTRL, 32'h1);
    rd(A_CNT, a); repeat (6) @(posedge clk); rd(A_CNT, b);
    check("R4 halt ignored without bit2", b - a, 32'd6);
    dbgHalt = 1'b0;

    // R5/R6/R7: match with interrupt, stop, drive-high
    wr(A_CTRL, 32'h2);
    wr(A_MVAL, 32'd20);
    wr(A_ACT, 32'h05);
    wr(A_PIN, 32'h20);
    wr(A_PULSE, 32'h0);
    wr(A_CTRL, 32'h1);
    repeat (40) @(posedge clk);
    rd(A_IRQ, a);   check("R5 flag set on match", a, 32'h1);
    check("R5 irq asserted", 32'(irqOut), 32'h1);
    rd(A_CNT, a);   check("R6 counter cleared on match", a, 32'h0);
    rd(A_CTRL, a);  check("R6 enable cleared on match", a, 32'h0);
    check("R7 pin driven high", 32'(matchPin), 32'h1);
    rd(A_PIN, a);   check("R7 pin register", a, 32'h21);
    check("R8 no pulse without enable", {30'h0, rstIntOut, rstExtOut}, 32'h0);
    rd(A_CAUSE, a); check("R10 cause clear without pulse", a, 32'h0);
    wr(A_IRQ, 32'h1);
    rd(A_IRQ, a);   check("R5 write-one clears flag", a, 32'h0);
    check("R5 irq released", 32'(irqOut), 32'h0);

    // R5 once, irq gating; R7 toggle
    wr(A_CTRL, 32'h2);
    wr(A_ACT, 32'h00);
    wr(A_MVAL, 32'd10);
    wr(A_PIN, 32'h31);
    wr(A_CTRL, 32'h1);
    repeat (30) @(posedge clk);
    rd(A_IRQ, a);   check("R5 flag set with irq disabled", a, 32'h1);
    check("R5 irq gated off", 32'(irqOut), 32'h0);
    check("R7 pin toggled", 32'(matchPin), 32'h0);
    wr(A_IRQ, 32'h1);
    repeat (30) @(posedge clk);
    rd(A_IRQ, a);   check("R5 fires only once", a, 32'h0);
    check("R7 toggled only once", 32'(matchPin), 32'h0);

    // R7 drive-low and keep
    wr(A_PIN, 32'h11);
    restart(); repeat (30) @(posedge clk);
    @(negedge clk); check("R7 pin driven low", 32'(matchPin), 32'h0);
    wr(A_PIN, 32'h01);
    restart(); repeat (30) @(posedge clk);
    @(negedge clk); check("R7 pin kept", 32'(matchPin), 32'h1);

    // R8: internal pulse of length 3+6
    wr(A_CTRL, 32'h2);
    wr(A_PULSE, 32'd3);
    wr(A_MVAL, 32'd8);
    wr(A_ACT, 32'h0C);
    wr(A_CTRL, 32'h1);
    hiInt = 0; hiExt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rstIntOut) hiInt++;
      if (rstExtOut) hiExt++;
    end
    check("R8 internal pulse width", 32'(hiInt), 32'd9);
    check("R8 external not selected", 32'(hiExt), 32'd0);
    rd(A_CAUSE, a); check("R10 cause set by pulse", a, 32'h1);

    // R8: longest external pulse
    wr(A_CTRL, 32'h2);
    wr(A_PULSE, 32'hFFFF);
    wr(A_ACT, 32'h14);
    wr(A_CTRL, 32'h1);
    hiInt = 0; hiExt = 0;
    for (int i = 0; i < 65600; i++) begin
      @(negedge clk);
      if (rstIntOut) hiInt++;
      if (rstExtOut) hiExt++;
    end
    check("R8 longest external pulse", 32'(hiExt), 32'd65541);
    check("R8 internal not selected", 32'(hiInt), 32'd0);

    // R9: forced outputs
    wr(A_ACT, 32'h20);
    @(negedge clk); check("R9 force internal", {30'h0, rstIntOut, rstExtOut}, 32'h2);
    wr(A_ACT, 32'h40);
    @(negedge clk); check("R9 force external", {30'h0, rstIntOut, rstExtOut}, 32'h1);
    wr(A_ACT, 32'h00);
    @(negedge clk); check("R9 release", {30'h0, rstIntOut, rstExtOut}, 32'h0);

    // R10/R11: cause flag sticky and read-only, cleared by power-on reset
    wr(A_CAUSE, 32'h0);
    restart();
    rd(A_CAUSE, a); check("R10 R11 cause survives writes", a, 32'h1);
    por();
    rd(A_CAUSE, a); check("R10 cleared by power-on reset", a, 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule